// File: doc/BRIEF.md
# Servo Phase Error Measurement Counter

This block measures the phase error of a servo loop as a signed 20-bit number. Software stages a start value for a counter through two write-only word registers: one carries the top four bits of the value and the other the low sixteen. Writing the low register moves the whole value into the active preset in one step. The high register on its own only stages bits. Software therefore writes the high register first and the low register second.

Each reference strobe loads the counter from the active preset. After that the counter steps up once on every cycle in which the divided-clock enable is high. A feedback strobe captures the current count into the error register. The captured value is shifted by the midpoint 0x80000, so an aligned loop reads zero and a lead or lag reads as a two's-complement number. The error output has a one-cycle valid pulse and no ready input. The consumer must take the value while valid is high, because nothing can hold off the producer, and the value stays on the port until the next capture.

A standby input clears all state and blocks every strobe and write while it is high.

Top module: `phase_err_latch`

## Requirements
- R1: A word write with `wr_addr_i`=1 sets the active preset to {staged high bits, `wr_data_i`[15:0]}. A word write with `wr_addr_i`=0 stages `wr_data_i`[3:0] as preset bits 19..16.
- R2: A write to the high register (`wr_addr_i`=0) alone leaves the active preset unchanged.
- R3: A write with `wr_word_i`=0 is ignored and changes neither the staged nor the active preset.
- R4: Reset, and any cycle with `standby_i` high, clear the staged bits, the active preset, the counter, `err_data_o` and `err_valid_o`. Strobes and writes seen while `standby_i` is high have no effect.
- R5: A reference strobe loads the counter with the active preset at the next edge and takes priority over the enable.
- R6: With no reference strobe, the counter adds one on each cycle with `cnt_en_i` high and wraps modulo 2^20.
- R7: A feedback strobe sets `err_data_o` to the count held before that edge minus 0x80000, modulo 2^20. This is the count with bit 19 inverted. A strobe that coincides with an enable captures the value before the increment.
- R8: `err_valid_o` is high for exactly the one cycle after each accepted feedback strobe. `err_data_o` holds its value between captures.
- R9: When reference and feedback strobes arrive in the same cycle, the capture takes the count from before the reload, and the counter then starts again from the preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | Standby: clears state and blocks activity |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Register select: 0 = high bits, 1 = low word (commit) |
| wr_word_i | input | 1 | 1 = word-wide access; 0 = byte access (ignored) |
| wr_data_i | input | 16 | Write data |
| cnt_en_i | input | 1 | Divided-clock count enable |
| ref_strobe_i | input | 1 | Phase reference event |
| fb_strobe_i | input | 1 | Phase feedback event |
| err_valid_o | output | 1 | One-cycle pulse marking a new error value |
| err_data_o | output | 20 | Latched signed phase error |

## Verification
The reload on a reference strobe and the capture on a feedback strobe can fall in the same cycle. The same is true of a capture and a count step. The bench drives the reference and feedback strobes on one edge, and it also drives the feedback strobe together with the enable. It then compares the captured error against a count model that takes the capture before applying the reload or the step. A follow-up measurement then confirms that the counter restarted from the preset or went on stepping.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  localparam int CNT_W = 20;
  localparam int LO_W  = 16;
  localparam int HI_W  = CNT_W - LO_W;
  typedef logic [CNT_W-1:0] cnt_t;
  typedef enum logic {SEL_HIGH = 1'b0, SEL_LOW = 1'b1} reg_sel_e;
endpackage

// File: rtl/ppc_preset_regs.sv
module ppc_preset_regs #(
  parameter int LO_W = ppc_pkg::LO_W,
  parameter int HI_W = ppc_pkg::HI_W,
  localparam int W   = LO_W + HI_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            standby,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic            wr_word,
  input  logic [LO_W-1:0] wr_data,
  output logic [HI_W-1:0] stage_hi,
  output logic [W-1:0]    preset
);
  import ppc_pkg::*;

  logic accept;
  assign accept = wr_en && wr_word && !standby;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_hi <= '0;
      preset   <= '0;
    end else if (standby) begin
      stage_hi <= '0;
      preset   <= '0;
    end else if (accept) begin
      if (wr_sel == SEL_LOW) preset   <= {stage_hi, wr_data};
      else                   stage_hi <= wr_data[HI_W-1:0];
    end
  end
endmodule

// File: rtl/ppc_counter.sv
module ppc_counter #(
  parameter int W = ppc_pkg::CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         standby,
  input  logic         load,
  input  logic         enable,
  input  logic [W-1:0] preset,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (standby) count <= '0;
    else if (load)    count <= preset;
    else if (enable)  count <= count + W'(1);
  end
endmodule

// File: rtl/ppc_err_latch.sv
module ppc_err_latch #(
  parameter int W = ppc_pkg::CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         standby,
  input  logic         capture,
  input  logic [W-1:0] count,
  output logic [W-1:0] err,
  output logic         valid
);
  localparam logic [W-1:0] MIDPOINT = {1'b1, {(W-1){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err   <= '0;
      valid <= 1'b0;
    end else if (standby) begin
      err   <= '0;
      valid <= 1'b0;
    end else begin
      valid <= capture;
      if (capture) err <= count - MIDPOINT;
    end
  end
endmodule

// File: rtl/phase_err_latch.sv
module phase_err_latch (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        standby_i,
  input  logic        wr_en_i,
  input  logic        wr_addr_i,
  input  logic        wr_word_i,
  input  logic [15:0] wr_data_i,
  input  logic        cnt_en_i,
  input  logic        ref_strobe_i,
  input  logic        fb_strobe_i,
  output logic        err_valid_o,
  output logic [19:0] err_data_o
);
  import ppc_pkg::*;

  logic [HI_W-1:0] stage_q;
  cnt_t            preset_q;
  cnt_t            cnt_q;

  ppc_preset_regs #(.LO_W(LO_W), .HI_W(HI_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .standby(standby_i),
    .wr_en(wr_en_i), .wr_sel(wr_addr_i), .wr_word(wr_word_i),
    .wr_data(wr_data_i), .stage_hi(stage_q), .preset(preset_q)
  );

  ppc_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .standby(standby_i),
    .load(ref_strobe_i), .enable(cnt_en_i),
    .preset(preset_q), .count(cnt_q)
  );

  ppc_err_latch #(.W(CNT_W)) u_err (
    .clk(clk), .rst_n(rst_n), .standby(standby_i),
    .capture(fb_strobe_i), .count(cnt_q),
    .err(err_data_o), .valid(err_valid_o)
  );
endmodule

// File: rtl/ppc_checker.sv
module ppc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        standby_i,
  input logic        wr_en_i,
  input logic        wr_addr_i,
  input logic        wr_word_i,
  input logic [15:0] wr_data_i,
  input logic        cnt_en_i,
  input logic        ref_strobe_i,
  input logic        fb_strobe_i,
  input logic        err_valid_o,
  input logic [19:0] err_data_o,
  input logic [3:0]  stage_q,
  input logic [19:0] preset_q,
  input logic [19:0] cnt_q
);
  p_commit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_word_i && wr_addr_i && !standby_i) |=>
      preset_q == {$past(stage_q), $past(wr_data_i)});

  p_high_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_addr_i && !standby_i) |=> $stable(preset_q));

  p_byte_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en_i && wr_word_i) && !standby_i) |=> ($stable(preset_q) && $stable(stage_q)));

  p_standby_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> (cnt_q == 20'd0 && preset_q == 20'd0 && err_data_o == 20'd0 && !err_valid_o));

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_strobe_i && !standby_i) |=> cnt_q == $past(preset_q));

  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_strobe_i && cnt_en_i && !standby_i) |=> cnt_q == $past(cnt_q) + 20'd1);

  p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_strobe_i && !standby_i) |=> err_data_o == ($past(cnt_q) ^ 20'h80000));

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_strobe_i && !standby_i) |=> err_valid_o);

  p_no_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fb_strobe_i && !standby_i) |=> !err_valid_o);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fb_strobe_i && !standby_i) |=> $stable(err_data_o));
endmodule

bind phase_err_latch ppc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .standby_i(standby_i),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_word_i(wr_word_i),
  .wr_data_i(wr_data_i), .cnt_en_i(cnt_en_i),
  .ref_strobe_i(ref_strobe_i), .fb_strobe_i(fb_strobe_i),
  .err_valid_o(err_valid_o), .err_data_o(err_data_o),
  .stage_q(stage_q), .preset_q(preset_q), .cnt_q(cnt_q)
);

// File: tb/phase_err_latch_bench.sv
`timescale 1ns/1ps
module phase_err_latch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        wr_addr_i = 1'b0;
  logic        wr_word_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        cnt_en_i = 1'b0;
  logic        ref_strobe_i = 1'b0;
  logic        fb_strobe_i = 1'b0;
  logic        err_valid_o;
  logic [19:0] err_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0]  m_stage = '0;
  logic [19:0] m_preset = '0;
  logic [19:0] m_cnt = '0;
  logic [19:0] m_err = '0;
  logic [19:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  phase_err_latch u_phase_err_latch (
    .clk(clk), .rst_n(rst_n), .standby_i(standby_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_word_i(wr_word_i),
    .wr_data_i(wr_data_i), .cnt_en_i(cnt_en_i),
    .ref_strobe_i(ref_strobe_i), .fb_strobe_i(fb_strobe_i),
    .err_valid_o(err_valid_o), .err_data_o(err_data_o)
  );

  task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle at a falling edge and advance the model as the requirements say
  task automatic cyc(input bit sb, input bit rf, input bit fb, input bit en,
                     input bit wr, input bit sel, input bit word,
                     input logic [15:0] d, input string tag);
    standby_i = sb; ref_strobe_i = rf; fb_strobe_i = fb; cnt_en_i = en;
    wr_en_i = wr; wr_addr_i = sel; wr_word_i = word; wr_data_i = d;
    if (sb) begin
      m_stage = '0; m_preset = '0; m_cnt = '0; m_err = '0;
    end else begin
      if (fb) begin
        m_err = m_cnt ^ 20'h80000;
        exp_q.push_back(m_err);
        tag_q.push_back(tag);
      end
      if (rf) m_cnt = m_preset;
      else if (en) m_cnt = m_cnt + 20'd1;
      if (wr && word) begin
        if (sel) m_preset = {m_stage, d};
        else     m_stage = d[3:0];
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(input bit en);
    cyc(0, 0, 0, en, 0, 0, 0, 16'h0, "");
  endtask

  task automatic wr_hi(input logic [15:0] d);
    cyc(0, 0, 0, 0, 1, 0, 1, d, "");
  endtask

  task automatic wr_lo(input logic [15:0] d);
    cyc(0, 0, 0, 0, 1, 1, 1, d, "");
  endtask

  task automatic measure(input int n, input string tag);
    cyc(0, 1, 0, 0, 0, 0, 0, 16'h0, tag);
    for (int i = 0; i < n; i++) idle(1);
    cyc(0, 0, 1, 0, 0, 0, 0, 16'h0, tag);
    idle(0);
    idle(0);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done && err_valid_o) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8: unexpected valid, actual %h expected none", err_data_o);
      end else begin
        automatic logic [19:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, err_data_o, e);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4 reset valid", {19'd0, err_valid_o}, 20'd0);
    check("R4 reset data", err_data_o, 20'd0);

    measure(5, "R4 reset preset zero");              // 0x80005
    wr_hi(16'h0007); wr_lo(16'hFFF6);
    measure(10, "R1 commit zero error");             // 0
    wr_hi(16'h0003);
    measure(10, "R2 high write alone");              // still 0
    cyc(0, 0, 0, 0, 1, 1, 0, 16'h1234, "");
    measure(10, "R3 byte write ignored");            // still 0
    wr_lo(16'h0000);
    measure(3, "R1 staged high used");               // 0xB0003
    wr_hi(16'h000F); wr_lo(16'hFFFE);
    measure(4, "R6 wrap");                           // 0x80002

    cyc(0, 1, 0, 1, 0, 0, 0, 16'h0, "");             // R5 load beats enable
    cyc(0, 0, 1, 0, 0, 0, 0, 16'h0, "R5 reload priority");
    idle(0);

    cyc(0, 1, 0, 0, 0, 0, 0, 16'h0, "");
    for (int i = 0; i < 7; i++) idle(1);
    cyc(0, 1, 1, 0, 0, 0, 0, 16'h0, "R9 same cycle capture");
    idle(1); idle(1);
    cyc(0, 0, 1, 0, 0, 0, 0, 16'h0, "R9 restart after reload");
    idle(0);

    cyc(0, 1, 0, 0, 0, 0, 0, 16'h0, "");
    for (int i = 0; i < 3; i++) idle(1);
    cyc(0, 0, 1, 1, 0, 0, 0, 16'h0, "R7 capture before step");
    cyc(0, 0, 1, 0, 0, 0, 0, 16'h0, "R7 step after capture");

    for (int i = 0; i < 5; i++) idle(1);
    check("R8 hold data", err_data_o, m_err);
    check("R8 no valid when idle", {19'd0, err_valid_o}, 20'd0);

    wr_hi(16'h0005);
    cyc(1, 1, 1, 1, 1, 1, 1, 16'hAAAA, "");
    check("R4 standby data", err_data_o, 20'd0);
    check("R4 standby valid", {19'd0, err_valid_o}, 20'd0);
    wr_lo(16'h0010);
    measure(2, "R4 standby cleared stage");          // 0x80012

    repeat (3) idle(0);
    check("R8 all captures seen", 20'(exp_q.size()), 20'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule